// File: doc/BRIEF.md
# Read-Response Reduction Fan-out

This block sits on the read path of a simplified single-beat AXI4-Lite style interconnect. A consumer master issues one read that carries a port mask and an operator code. The block presents that read to every producer slave named in the mask, all at once. It captures one read response from each of those slaves, in whatever order the responses arrive. It folds their data together with the chosen operator and returns a single read response to the consumer.

The consumer starts the reduction, and the producers are ordinary read slaves that need no change. Only one reduction is in flight at a time. The status code returned to the consumer is the most severe code reported by any targeted slave. An empty mask is answered at once with a decode error, and no slave is touched.

Top module: `rr_read_reduce`

## Requirements
- R1: While reset is held and in the first cycle after it, `cons_ar_ready_o` is 1, while `cons_r_valid_o`, `prod_ar_valid_o` and `prod_r_ready_o` are all 0.
- R2: In the cycle after a read with a non-zero mask is accepted, `prod_ar_valid_o` equals the mask (bit i targets producer i), and `prod_ar_addr_o` carries the accepted address.
- R3: A producer port that completes its address handshake sees `prod_ar_valid_o` low from the next cycle on. Targeted ports that have not yet accepted keep seeing it high.
- R4: `prod_r_ready_o[i]` is high for each targeted port from the cycle after acceptance until that port's response is captured, and low afterwards. Ports outside the mask never see valid or ready.
- R5: Responses may arrive in any order, or in the same cycle. `cons_r_valid_o` rises in the cycle after the last targeted response is captured.
- R6: Operator code 2'b00 returns the sum of the collected data, modulo 2^DATA_W.
- R7: Operator code 2'b01 returns the bitwise AND, 2'b10 the bitwise OR and 2'b11 the unsigned maximum of the collected data.
- R8: The returned code is the worst collected. 2'b11 (decode error) ranks above 2'b10 (slave error), which ranks above 2'b00. A collected 2'b01 counts as 2'b00.
- R9: An all-zero mask asserts no producer valid. The cycle after acceptance, `cons_r_valid_o` is 1 with response 2'b11 and data 0.
- R10: From acceptance until the consumer read-data handshake, `cons_ar_ready_o` is 0. While the consumer stalls, the pending response holds its data and code stable. `cons_ar_ready_o` returns to 1 in the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cons_ar_valid_i | input | 1 | Consumer read address valid |
| cons_ar_ready_o | output | 1 | Consumer read address ready |
| cons_ar_addr_i | input | ADDR_W | Consumer read address |
| cons_ar_mask_i | input | NUM_SLV | Producer target mask |
| cons_ar_op_i | input | 2 | Reduction operator code |
| cons_r_valid_o | output | 1 | Reduced response valid |
| cons_r_ready_i | input | 1 | Consumer ready for response |
| cons_r_data_o | output | DATA_W | Reduced data |
| cons_r_resp_o | output | 2 | Merged response code |
| prod_ar_valid_o | output | NUM_SLV | Per-producer address valid |
| prod_ar_ready_i | input | NUM_SLV | Per-producer address ready |
| prod_ar_addr_o | output | ADDR_W | Address shared by all producers |
| prod_r_valid_i | input | NUM_SLV | Per-producer response valid |
| prod_r_ready_o | output | NUM_SLV | Per-producer response ready |
| prod_r_data_i | input | NUM_SLV*DATA_W | Producer data, port i at bits i*DATA_W |
| prod_r_resp_i | input | NUM_SLV*2 | Producer codes, port i at bits 2*i |

## Verification
Every result here is one register stage behind its cause. The fan-out valids and the address appear one cycle after the consumer handshake. A producer valid drops one cycle after that producer's handshake. The reduced response is up one cycle after the last producer response is captured, and for an empty mask one cycle after acceptance. The bench drives all inputs on the falling edge and samples on the falling edge that directly follows the rising edge where each result is due. It does so by forking one producer model per targeted port, then checking the consumer response on the very falling edge at which the last model finishes. The stall and the ready-return checks are likewise made one falling edge after the handshake they follow.

// File: rtl/rr_pkg.sv
package rr_pkg;

   typedef enum logic [1:0] {
      RED_SUM = 2'b00,
      RED_AND = 2'b01,
      RED_OR  = 2'b10,
      RED_MAX = 2'b11
   } red_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_BUSY,
      ST_REPLY
   } red_state_e;

   localparam logic [1:0] CODE_OKAY   = 2'b00;
   localparam logic [1:0] CODE_DECERR = 2'b11;

   // Severity rank: errors keep their code, both success codes map to 00.
   function automatic logic [1:0] code_rank(input logic [1:0] code);
      return code[1] ? code : CODE_OKAY;
   endfunction

endpackage

// File: rtl/rr_pend_track.sv
module rr_pend_track #(
   parameter int WIDTH = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_mask_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] pend_o
);

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      always_ff @(posedge clk_i) begin
         if (!rst_ni)        pend_o[g] <= 1'b0;
         else if (load_i)    pend_o[g] <= load_mask_i[g];
         else if (clr_i[g])  pend_o[g] <= 1'b0;
      end
   end

endmodule

// File: rtl/rr_combine.sv
module rr_combine
   import rr_pkg::*;
#(
   parameter int NUM_LANES = 4,
   parameter int DATA_W    = 32
) (
   input  red_op_e                       op_i,
   input  logic [DATA_W-1:0]             acc_data_i,
   input  logic [1:0]                    acc_code_i,
   input  logic [NUM_LANES-1:0]          take_i,
   input  logic [NUM_LANES*DATA_W-1:0]   lane_data_i,
   input  logic [NUM_LANES*2-1:0]        lane_code_i,
   output logic [DATA_W-1:0]             nxt_data_o,
   output logic [1:0]                    nxt_code_o
);

   function automatic logic [DATA_W-1:0] fold(input red_op_e op,
                                              input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
      case (op)
         RED_SUM: return a + b;
         RED_AND: return a & b;
         RED_OR:  return a | b;
         default: return (a > b) ? a : b;
      endcase
   endfunction

   always_comb begin
      nxt_data_o = acc_data_i;
      nxt_code_o = acc_code_i;
      for (int i = 0; i < NUM_LANES; i++) begin
         if (take_i[i]) begin
            nxt_data_o = fold(op_i, nxt_data_o, lane_data_i[i*DATA_W +: DATA_W]);
            if (code_rank(lane_code_i[2*i +: 2]) > nxt_code_o)
               nxt_code_o = code_rank(lane_code_i[2*i +: 2]);
         end
      end
   end

endmodule

// File: rtl/rr_read_reduce.sv
module rr_read_reduce
   import rr_pkg::*;
#(
   parameter int NUM_SLV = 4,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      cons_ar_valid_i,
   output logic                      cons_ar_ready_o,
   input  logic [ADDR_W-1:0]         cons_ar_addr_i,
   input  logic [NUM_SLV-1:0]        cons_ar_mask_i,
   input  logic [1:0]                cons_ar_op_i,
   output logic                      cons_r_valid_o,
   input  logic                      cons_r_ready_i,
   output logic [DATA_W-1:0]         cons_r_data_o,
   output logic [1:0]                cons_r_resp_o,
   output logic [NUM_SLV-1:0]        prod_ar_valid_o,
   input  logic [NUM_SLV-1:0]        prod_ar_ready_i,
   output logic [ADDR_W-1:0]         prod_ar_addr_o,
   input  logic [NUM_SLV-1:0]        prod_r_valid_i,
   output logic [NUM_SLV-1:0]        prod_r_ready_o,
   input  logic [NUM_SLV*DATA_W-1:0] prod_r_data_i,
   input  logic [NUM_SLV*2-1:0]      prod_r_resp_i
);

   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

   initial begin : param_checks
      assert (NUM_SLV >= 1) else $error("NUM_SLV must be at least 1");
      assert (DATA_W >= 1)  else $error("DATA_W must be at least 1");
      assert (ADDR_W >= 1)  else $error("ADDR_W must be at least 1");
   end

   red_state_e          state_q;
   red_op_e             op_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   acc_data_q, nxt_data;
   logic [1:0]          acc_code_q, nxt_code;
   logic [NUM_SLV-1:0]  ar_pend, r_pend, ar_hs, r_hs;
   logic                accept, empty_mask, all_in;
   red_op_e             req_op;

   assign req_op     = red_op_e'(cons_ar_op_i);
   assign accept     = cons_ar_valid_i && (state_q == ST_IDLE);
   assign empty_mask = (cons_ar_mask_i == '0);
   assign ar_hs      = ar_pend & prod_ar_ready_i;
   assign r_hs       = r_pend & prod_r_valid_i;
   assign all_in     = ((r_pend & ~r_hs) == '0);

   rr_pend_track #(.WIDTH(NUM_SLV)) u_ar_track (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
      .load_mask_i(cons_ar_mask_i), .clr_i(ar_hs), .pend_o(ar_pend)
   );

   rr_pend_track #(.WIDTH(NUM_SLV)) u_r_track (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
      .load_mask_i(cons_ar_mask_i), .clr_i(r_hs), .pend_o(r_pend)
   );

   rr_combine #(.NUM_LANES(NUM_SLV), .DATA_W(DATA_W)) u_combine (
      .op_i(op_q), .acc_data_i(acc_data_q), .acc_code_i(acc_code_q),
      .take_i(r_hs), .lane_data_i(prod_r_data_i), .lane_code_i(prod_r_resp_i),
      .nxt_data_o(nxt_data), .nxt_code_o(nxt_code)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         op_q       <= RED_SUM;
         addr_q     <= '0;
         acc_data_q <= '0;
         acc_code_q <= CODE_OKAY;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               op_q   <= req_op;
               addr_q <= cons_ar_addr_i;
               if (empty_mask) begin
                  acc_data_q <= '0;
                  acc_code_q <= CODE_DECERR;
                  state_q    <= ST_REPLY;
               end else begin
                  acc_data_q <= (req_op == RED_AND) ? ALL_ONES : '0;
                  acc_code_q <= CODE_OKAY;
                  state_q    <= ST_BUSY;
               end
            end
            ST_BUSY: begin
               acc_data_q <= nxt_data;
               acc_code_q <= nxt_code;
               if (all_in) state_q <= ST_REPLY;
            end
            default: if (cons_r_ready_i) state_q <= ST_IDLE;
         endcase
      end
   end

   assign cons_ar_ready_o = (state_q == ST_IDLE);
   assign cons_r_valid_o  = (state_q == ST_REPLY);
   assign cons_r_data_o   = acc_data_q;
   assign cons_r_resp_o   = acc_code_q;
   assign prod_ar_valid_o = ar_pend;
   assign prod_ar_addr_o  = addr_q;
   assign prod_r_ready_o  = r_pend;

endmodule

// File: rtl/rr_read_reduce_chk.sv
module rr_read_reduce_chk #(
   parameter int NUM_SLV = 4,
   parameter int DATA_W  = 32
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               cons_ar_valid_i,
   input logic               cons_ar_ready_o,
   input logic [NUM_SLV-1:0] cons_ar_mask_i,
   input logic               cons_r_valid_o,
   input logic               cons_r_ready_i,
   input logic [DATA_W-1:0]  cons_r_data_o,
   input logic [1:0]         cons_r_resp_o,
   input logic [NUM_SLV-1:0] prod_ar_valid_o,
   input logic [NUM_SLV-1:0] prod_ar_ready_i,
   input logic [NUM_SLV-1:0] prod_r_ready_o
);

   assert_fanout_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cons_ar_valid_i && cons_ar_ready_o && (cons_ar_mask_i != '0))
      |=> (prod_ar_valid_o == $past(cons_ar_mask_i)));

   assert_ar_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(prod_ar_valid_o & prod_ar_ready_i))
      |=> ((prod_ar_valid_o & $past(prod_ar_valid_o & prod_ar_ready_i)) == '0));

   assert_quiet_reply_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cons_r_valid_o |-> ((prod_ar_valid_o == '0) && (prod_r_ready_o == '0)));

   assert_empty_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cons_ar_valid_i && cons_ar_ready_o && (cons_ar_mask_i == '0))
      |=> (cons_r_valid_o && (cons_r_resp_o == 2'b11) && (cons_r_data_o == '0)));

   assert_reply_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cons_r_valid_o && !cons_r_ready_i)
      |=> (cons_r_valid_o && $stable(cons_r_data_o) && $stable(cons_r_resp_o)));

   assert_single_flight_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cons_r_valid_o |-> !cons_ar_ready_o);

endmodule

bind rr_read_reduce rr_read_reduce_chk #(.NUM_SLV(NUM_SLV), .DATA_W(DATA_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni),
   .cons_ar_valid_i(cons_ar_valid_i), .cons_ar_ready_o(cons_ar_ready_o),
   .cons_ar_mask_i(cons_ar_mask_i), .cons_r_valid_o(cons_r_valid_o),
   .cons_r_ready_i(cons_r_ready_i), .cons_r_data_o(cons_r_data_o),
   .cons_r_resp_o(cons_r_resp_o), .prod_ar_valid_o(prod_ar_valid_o),
   .prod_ar_ready_i(prod_ar_ready_i), .prod_r_ready_o(prod_r_ready_o)
);

// File: tb/tb_rr_read_reduce.sv
module tb_rr_read_reduce;

   localparam int N  = 4;
   localparam int AW = 32;
   localparam int DW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            c_ar_valid = 1'b0;
   logic            c_ar_ready;
   logic [AW-1:0]   c_ar_addr = '0;
   logic [N-1:0]    c_ar_mask = '0;
   logic [1:0]      c_ar_op = 2'b00;
   logic            c_r_valid;
   logic            c_r_ready = 1'b0;
   logic [DW-1:0]   c_r_data;
   logic [1:0]      c_r_resp;
   logic [N-1:0]    p_ar_valid;
   logic [N-1:0]    p_ar_ready = '0;
   logic [AW-1:0]   p_ar_addr;
   logic [N-1:0]    p_r_valid = '0;
   logic [N-1:0]    p_r_ready;
   logic [N*DW-1:0] p_r_data = '0;
   logic [N*2-1:0]  p_r_resp = '0;

   int n_chk = 0;
   int n_bad = 0;
   int ar_lat [N];
   int r_lat  [N];
   logic [DW-1:0] s_data [N];
   logic [1:0]    s_code [N];

   always #4 clk = ~clk;

   rr_read_reduce #(.NUM_SLV(N), .ADDR_W(AW), .DATA_W(DW)) dut (
      .clk_i(clk), .rst_ni(rst_n),
      .cons_ar_valid_i(c_ar_valid), .cons_ar_ready_o(c_ar_ready),
      .cons_ar_addr_i(c_ar_addr), .cons_ar_mask_i(c_ar_mask), .cons_ar_op_i(c_ar_op),
      .cons_r_valid_o(c_r_valid), .cons_r_ready_i(c_r_ready),
      .cons_r_data_o(c_r_data), .cons_r_resp_o(c_r_resp),
      .prod_ar_valid_o(p_ar_valid), .prod_ar_ready_i(p_ar_ready), .prod_ar_addr_o(p_ar_addr),
      .prod_r_valid_i(p_r_valid), .prod_r_ready_o(p_r_ready),
      .prod_r_data_i(p_r_data), .prod_r_resp_i(p_r_resp)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] model_data(input logic [N-1:0] m, input logic [1:0] op);
      logic [DW-1:0] v;
      bit first = 1'b1;
      v = '0;
      for (int i = 0; i < N; i++) begin
         if (m[i]) begin
            if (first) v = s_data[i];
            else case (op)
               2'b00: v = v + s_data[i];
               2'b01: v = v & s_data[i];
               2'b10: v = v | s_data[i];
               default: if (s_data[i] > v) v = s_data[i];
            endcase
            first = 1'b0;
         end
      end
      return v;
   endfunction

   function automatic logic [1:0] model_code(input logic [N-1:0] m);
      bit dec = 1'b0, slv = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (m[i] && s_code[i] == 2'b11) dec = 1'b1;
         if (m[i] && s_code[i] == 2'b10) slv = 1'b1;
      end
      return dec ? 2'b11 : (slv ? 2'b10 : 2'b00);
   endfunction

   task automatic producer(input int k);
      do @(negedge clk); while (!p_ar_valid[k]);
      repeat (ar_lat[k]) @(negedge clk);
      check(p_ar_valid[k] == 1'b1, "R3", "valid kept until accepted", 64'(p_ar_valid[k]), 1);
      p_ar_ready[k] = 1'b1;
      @(negedge clk);
      p_ar_ready[k] = 1'b0;
      check(p_ar_valid[k] == 1'b0, "R3", "valid dropped after accept", 64'(p_ar_valid[k]), 0);
      repeat (r_lat[k]) @(negedge clk);
      check(p_r_ready[k] == 1'b1, "R4", "response ready while waiting", 64'(p_r_ready[k]), 1);
      p_r_valid[k] = 1'b1;
      p_r_data[k*DW +: DW] = s_data[k];
      p_r_resp[k*2 +: 2]   = s_code[k];
      @(negedge clk);
      p_r_valid[k] = 1'b0;
      check(p_r_ready[k] == 1'b0, "R4", "response ready low after capture", 64'(p_r_ready[k]), 0);
   endtask

   task automatic run_reduce(input logic [N-1:0] m, input logic [1:0] op,
                             input logic [AW-1:0] addr, input string req);
      logic [DW-1:0] exp_d;
      logic [1:0]    exp_c;
      exp_d = model_data(m, op);
      exp_c = model_code(m);
      for (int i = 0; i < N; i++) begin
         if (m[i]) begin
            automatic int k = i;
            fork producer(k); join_none
         end
      end
      c_ar_valid = 1'b1; c_ar_addr = addr; c_ar_mask = m; c_ar_op = op;
      @(negedge clk);
      c_ar_valid = 1'b0;
      check(p_ar_valid == m, "R2", "fan-out valid equals mask", 64'(p_ar_valid), 64'(m));
      check(p_ar_addr == addr, "R2", "address forwarded", 64'(p_ar_addr), 64'(addr));
      check(c_ar_ready == 1'b0, "R10", "not ready while busy", 64'(c_ar_ready), 0);
      wait fork;
      check(c_r_valid == 1'b1, "R5", "reply one cycle after last response", 64'(c_r_valid), 1);
      check(c_r_data == exp_d, req, "reduced data", 64'(c_r_data), 64'(exp_d));
      check(c_r_resp == exp_c, "R8", "merged code", 64'(c_r_resp), 64'(exp_c));
      check((p_ar_valid | p_r_ready) == '0, "R4", "producers idle during reply",
            64'(p_ar_valid | p_r_ready), 0);
      c_ar_valid = 1'b1; c_ar_mask = '1;
      repeat (2) @(negedge clk);
      check(c_r_valid && c_r_data == exp_d && c_r_resp == exp_c, "R10", "reply held under stall",
            64'(c_r_data), 64'(exp_d));
      check(c_ar_ready == 1'b0, "R10", "second read refused", 64'(c_ar_ready), 0);
      c_ar_valid = 1'b0;
      c_r_ready = 1'b1;
      @(negedge clk);
      c_r_ready = 1'b0;
      check(c_r_valid == 1'b0 && c_ar_ready == 1'b1, "R10", "ready returns after handshake",
            64'({c_r_valid, c_ar_ready}), 64'b01);
      check(p_ar_valid == '0, "R10", "refused read not started", 64'(p_ar_valid), 0);
   endtask

   task automatic setup(input logic [DW-1:0] d0, d1, d2, d3,
                        input logic [1:0] c0, c1, c2, c3,
                        input int a0, a1, a2, a3, input int q0, q1, q2, q3);
      s_data[0] = d0; s_data[1] = d1; s_data[2] = d2; s_data[3] = d3;
      s_code[0] = c0; s_code[1] = c1; s_code[2] = c2; s_code[3] = c3;
      ar_lat[0] = a0; ar_lat[1] = a1; ar_lat[2] = a2; ar_lat[3] = a3;
      r_lat[0] = q0;  r_lat[1] = q1;  r_lat[2] = q2;  r_lat[3] = q3;
   endtask

   task automatic t_reset;
      check(c_ar_ready == 1'b1, "R1", "ar ready in reset", 64'(c_ar_ready), 1);
      check(c_r_valid == 1'b0, "R1", "no reply in reset", 64'(c_r_valid), 0);
      check((p_ar_valid | p_r_ready) == '0, "R1", "producers idle in reset",
            64'(p_ar_valid | p_r_ready), 0);
   endtask

   task automatic t_sum_out_of_order;
      setup(10, 20, 30, 40, 0, 0, 0, 0, 0, 2, 1, 3, 5, 0, 3, 1);
      run_reduce(4'b1111, 2'b00, 32'h1000, "R6");
   endtask

   task automatic t_sum_wrap;
      setup(32'hFFFF_FFFF, 0, 2, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 2, 0);
      run_reduce(4'b0101, 2'b00, 32'h2000, "R6");
   endtask

   task automatic t_and;
      setup(32'hF0F0_FFFF, 32'h1234_5678, 32'hFF00_FF0F, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 0, 0);
      run_reduce(4'b0111, 2'b01, 32'h3000, "R7");
   endtask

   task automatic t_or;
      setup(32'h1, 32'h10, 32'h100, 32'h8000_0000, 0, 0, 0, 0, 2, 0, 1, 0, 0, 2, 0, 1);
      run_reduce(4'b1010, 2'b10, 32'h4000, "R7");
   endtask

   task automatic t_max_unsigned;
      setup(32'h7FFF_FFFF, 32'h8000_0000, 32'h5, 32'hFFFF_0000, 0, 0, 0, 0, 0, 1, 0, 2, 3, 0, 2, 0);
      run_reduce(4'b0111, 2'b11, 32'h5000, "R7");
   endtask

   task automatic t_code_merge;
      setup(1, 2, 3, 4, 2'b00, 2'b10, 2'b01, 2'b00, 0, 0, 0, 0, 0, 1, 2, 3);
      run_reduce(4'b1111, 2'b00, 32'h6000, "R8");
      setup(1, 2, 3, 4, 2'b10, 2'b11, 2'b00, 2'b10, 0, 0, 0, 0, 2, 0, 1, 0);
      run_reduce(4'b1011, 2'b10, 32'h6100, "R8");
      setup(1, 2, 3, 4, 2'b01, 2'b01, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
      run_reduce(4'b0011, 2'b00, 32'h6200, "R8");
   endtask

   task automatic t_simultaneous;
      setup(3, 5, 7, 11, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1);
      run_reduce(4'b1111, 2'b00, 32'h7000, "R5");
   endtask

   task automatic t_single_port;
      setup(0, 0, 0, 32'hABCD, 0, 0, 0, 2'b10, 0, 0, 0, 1, 0, 0, 0, 2);
      run_reduce(4'b1000, 2'b11, 32'h8000, "R4");
   endtask

   task automatic t_empty_mask;
      c_ar_valid = 1'b1; c_ar_mask = '0; c_ar_op = 2'b01; c_ar_addr = 32'h9000;
      @(negedge clk);
      c_ar_valid = 1'b0;
      check(c_r_valid == 1'b1, "R9", "immediate reply", 64'(c_r_valid), 1);
      check(c_r_resp == 2'b11, "R9", "decode error code", 64'(c_r_resp), 64'b11);
      check(c_r_data == '0, "R9", "zero data", 64'(c_r_data), 0);
      check(p_ar_valid == '0, "R9", "no producer valid", 64'(p_ar_valid), 0);
      c_r_ready = 1'b1;
      @(negedge clk);
      c_r_ready = 1'b0;
      check(c_ar_ready == 1'b1 && c_r_valid == 1'b0, "R10", "idle after empty reply",
            64'({c_r_valid, c_ar_ready}), 64'b01);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_sum_out_of_order;
      t_sum_wrap;
      t_and;
      t_or;
      t_max_unsigned;
      t_code_merge;
      t_simultaneous;
      t_single_port;
      t_empty_mask;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule